// File: doc/BRIEF.md
# Triple-Buffered Frame Bank Controller

This controller sequences three external low-resolution frame banks that feed an iterative image reconstruction engine. The engine works in stages. In every stage one bank takes in the next group of four incoming frames. The other two banks are read together: one holds the most recently completed group (the main frames) and the other holds the group before it (the neighbouring frames). The 32-bit word datapath and the memory timing are handled elsewhere. This block only decides which bank plays which role and which frame slot is being addressed.

A three-state machine rotates the bank roles at each stage boundary. A boundary is accepted only when the engine reports that its stage is done and the incoming group is completely written. If the engine finishes first, the controller raises a stall flag and rotates as soon as the last frame of the group arrives. Read requests are given as an index over the eight frames held in the two read banks, oldest first. The index is translated into a registered bank number, slot number and validity flag. Validity stays low for banks that have not yet been filled after reset.

Top module: `frame_bank_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it is released, stage_state is 00, bank_we is 001, wr_slot is 0, main_sel is 2, nbr_sel is 1, and stall, main_valid, nbr_valid and rd_ok are 0.
- R2: stage_state only takes the values 00, 10 and 01 and advances in the order 00→10→01→00. The bank roles are: in 00 bank 0 is written, bank 2 is main and bank 1 is neighbour; in 10 the written, main and neighbour banks are 1, 0 and 2; in 01 they are 2, 1 and 0.
- R3: Each frame_wr_done pulse moves wr_slot on by one, starting from 0. bank_we is one-hot with bit b standing for bank b while fewer than four frames of the group are written. Once four are written, bank_we is 000, wr_slot stays at 3, and further pulses have no effect.
- R4: A stage_done pulse that arrives while the group is complete advances stage_state on that same clock edge. The new write bank starts again at slot 0.
- R5: A stage_done pulse that arrives while the group is incomplete sets stall on the next edge and leaves stage_state unchanged. On the edge after the group becomes complete, the state advances and stall clears.
- R6: main_valid becomes 1 at the first advance after reset. nbr_valid becomes 1 at the second advance. Both then stay at 1 until reset.
- R7: main_sel and nbr_sel give the main and neighbour bank numbers of the state. They are registered, so they change one cycle after stage_state changes.
- R8: One cycle after rd_idx is applied, rd_bank and rd_slot give the bank and slot of that frame. Indexes 0–3 map to the neighbour bank at slot rd_idx, and indexes 4–7 map to the main bank at slot rd_idx−4. rd_ok repeats nbr_valid or main_valid accordingly.
- R9: A stage_done pulse that arrives while stall is already set causes no second advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stage_done | input | 1 | One-cycle pulse: the engine has finished its stage |
| frame_wr_done | input | 1 | One-cycle pulse: one incoming frame is fully stored |
| rd_idx | input | 3 | Index of the frame to read among the eight in the read banks, oldest first |
| stage_state | output | 2 | Current bank-role configuration (00, 10, 01) |
| bank_we | output | 3 | Per-bank write enable, bit b for bank b |
| wr_slot | output | 2 | Frame slot being written in the write bank |
| main_sel | output | 2 | Bank number holding the main frames (registered) |
| nbr_sel | output | 2 | Bank number holding the neighbouring frames (registered) |
| main_valid | output | 1 | Main bank holds a completed group |
| nbr_valid | output | 1 | Neighbour bank holds a completed group |
| stall | output | 1 | Stage finished but incoming group not yet complete |
| rd_bank | output | 2 | Bank number for the frame selected by rd_idx |
| rd_slot | output | 2 | Slot number for the frame selected by rd_idx |
| rd_ok | output | 1 | The selected frame's bank holds valid data |

## Verification
A wrong role state shows on bank_we in the same cycle, and on main_sel, nbr_sel and rd_bank one cycle later. A slip in the frame count appears on wr_slot at the next write pulse, or as bank_we dropping early or late. A lost stall shows up as a missing rotation in the cycle after the group completes. A lost or early validity flag shows on rd_ok within one cycle of the read index being applied.

// File: rtl/fbc_pkg.sv
package fbc_pkg;

  localparam int NUM_BANKS = 3;
  localparam int BANK_W    = 2;

  typedef enum logic [1:0] {
    CFG_A = 2'b00,
    CFG_B = 2'b10,
    CFG_C = 2'b01
  } cfg_e;

  typedef struct packed {
    logic [BANK_W-1:0] wr;
    logic [BANK_W-1:0] main;
    logic [BANK_W-1:0] nbr;
  } roles_t;

  function automatic roles_t roles_of(cfg_e c);
    roles_t r;
    case (c)
      CFG_B:   begin r.wr = 2'd1; r.main = 2'd0; r.nbr = 2'd2; end
      CFG_C:   begin r.wr = 2'd2; r.main = 2'd1; r.nbr = 2'd0; end
      default: begin r.wr = 2'd0; r.main = 2'd2; r.nbr = 2'd1; end
    endcase
    return r;
  endfunction

  function automatic cfg_e next_cfg(cfg_e c);
    case (c)
      CFG_A:   return CFG_B;
      CFG_B:   return CFG_C;
      default: return CFG_A;
    endcase
  endfunction

endpackage

// File: rtl/fbc_write_track.sv
module fbc_write_track #(
  parameter int GROUP_FRAMES = 4,
  localparam int CNT_W = $clog2(GROUP_FRAMES) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_wr_done,
  input  logic             clear,
  output logic [CNT_W-1:0] cnt,
  output logic             full
);

  assign full = (cnt == CNT_W'(GROUP_FRAMES));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (frame_wr_done && !full) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R3: count never passes the group size and holds once full
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(GROUP_FRAMES));
  p_full_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (full && !clear) |=> full);

endmodule

// File: rtl/fbc_role_fsm.sv
module fbc_role_fsm
  import fbc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic stage_done,
  input  logic group_full,
  output cfg_e cfg,
  output logic advance,
  output logic stall,
  output logic main_valid,
  output logic nbr_valid
);

  logic       pending;
  logic [1:0] fills;

  assign pending = stage_done || stall;
  assign advance = pending && group_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg   <= CFG_A;
      stall <= 1'b0;
      fills <= 2'd0;
    end else begin
      stall <= pending && !group_full;
      if (advance) begin
        cfg <= next_cfg(cfg);
        if (fills != 2'd2) fills <= fills + 2'd1;
      end
    end
  end

  assign main_valid = (fills != 2'd0);
  assign nbr_valid  = (fills == 2'd2);

  // R2: only the three legal encodings
  p_cfg_legal_r2: assert property (@(posedge clk) disable iff (rst)
    (cfg == CFG_A) || (cfg == CFG_B) || (cfg == CFG_C));
  // R4: state moves only when the group was complete
  p_move_needs_full_r4: assert property (@(posedge clk) disable iff (rst)
    (cfg != $past(cfg)) |-> $past(group_full));
  // R5: a raised stall freezes the state
  p_stall_holds_r5: assert property (@(posedge clk) disable iff (rst)
    (stall && !group_full) |=> $stable(cfg));
  // R6: validity never drops without reset
  p_valid_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    main_valid |=> main_valid);
  p_nbr_implies_main_r6: assert property (@(posedge clk) disable iff (rst)
    nbr_valid |-> main_valid);

endmodule

// File: rtl/fbc_read_map.sv
module fbc_read_map
  import fbc_pkg::*;
#(
  parameter int GROUP_FRAMES = 4,
  localparam int SLOT_W = $clog2(GROUP_FRAMES),
  localparam int IDX_W  = SLOT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  cfg_e              cfg,
  input  logic              main_valid,
  input  logic              nbr_valid,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [BANK_W-1:0] main_sel,
  output logic [BANK_W-1:0] nbr_sel,
  output logic [BANK_W-1:0] rd_bank,
  output logic [SLOT_W-1:0] rd_slot,
  output logic              rd_ok
);

  roles_t roles;
  logic   in_main;

  assign roles   = roles_of(cfg);
  assign in_main = rd_idx[SLOT_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      main_sel <= 2'd2;
      nbr_sel  <= 2'd1;
      rd_bank  <= 2'd1;
      rd_slot  <= '0;
      rd_ok    <= 1'b0;
    end else begin
      main_sel <= roles.main;
      nbr_sel  <= roles.nbr;
      rd_bank  <= in_main ? roles.main : roles.nbr;
      rd_slot  <= rd_idx[SLOT_W-1:0];
      rd_ok    <= in_main ? main_valid : nbr_valid;
    end
  end

  // R7: read banks are always two different banks
  p_sel_distinct_r7: assert property (@(posedge clk) disable iff (rst)
    main_sel != nbr_sel);
  // R8: the read bank is one of the two read banks of the previous cycle's state
  p_rd_in_pair_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_bank == roles_of($past(cfg)).main) || (rd_bank == roles_of($past(cfg)).nbr));

endmodule

// File: rtl/frame_bank_ctrl.sv
module frame_bank_ctrl
  import fbc_pkg::*;
#(
  parameter int GROUP_FRAMES = 4,
  localparam int SLOT_W = $clog2(GROUP_FRAMES),
  localparam int IDX_W  = SLOT_W + 1,
  localparam int CNT_W  = SLOT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stage_done,
  input  logic              frame_wr_done,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [1:0]        stage_state,
  output logic [NUM_BANKS-1:0] bank_we,
  output logic [SLOT_W-1:0] wr_slot,
  output logic [BANK_W-1:0] main_sel,
  output logic [BANK_W-1:0] nbr_sel,
  output logic              main_valid,
  output logic              nbr_valid,
  output logic              stall,
  output logic [BANK_W-1:0] rd_bank,
  output logic [SLOT_W-1:0] rd_slot,
  output logic              rd_ok
);

  logic [CNT_W-1:0] cnt;
  logic             full;
  logic             advance;
  cfg_e             cfg;
  roles_t           roles;

  fbc_write_track #(.GROUP_FRAMES(GROUP_FRAMES)) u_wr (
    .clk           (clk),
    .rst           (rst),
    .frame_wr_done (frame_wr_done),
    .clear         (advance),
    .cnt           (cnt),
    .full          (full)
  );

  fbc_role_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .stage_done (stage_done),
    .group_full (full),
    .cfg        (cfg),
    .advance    (advance),
    .stall      (stall),
    .main_valid (main_valid),
    .nbr_valid  (nbr_valid)
  );

  fbc_read_map #(.GROUP_FRAMES(GROUP_FRAMES)) u_rd (
    .clk        (clk),
    .rst        (rst),
    .cfg        (cfg),
    .main_valid (main_valid),
    .nbr_valid  (nbr_valid),
    .rd_idx     (rd_idx),
    .main_sel   (main_sel),
    .nbr_sel    (nbr_sel),
    .rd_bank    (rd_bank),
    .rd_slot    (rd_slot),
    .rd_ok      (rd_ok)
  );

  assign roles       = roles_of(cfg);
  assign stage_state = cfg;
  assign wr_slot     = full ? {SLOT_W{1'b1}} : cnt[SLOT_W-1:0];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_we
    assign bank_we[b] = !full && (roles.wr == BANK_W'(b));
  end

  // R3: exactly one bank written while the group is open, none once full
  p_we_open_r3: assert property (@(posedge clk) disable iff (rst)
    !full |-> $onehot(bank_we));
  p_we_full_r3: assert property (@(posedge clk) disable iff (rst)
    full |-> (bank_we == '0));
  // R9: a stage_done during stall cannot advance an incomplete group
  p_no_double_r9: assert property (@(posedge clk) disable iff (rst)
    (stall && stage_done && !full) |=> $stable(stage_state));

endmodule

// File: tb/test_frame_bank_ctrl.sv
module test_frame_bank_ctrl;

  logic       clk = 1'b0;
  logic       rst;
  logic       stage_done;
  logic       frame_wr_done;
  logic [2:0] rd_idx;
  logic [1:0] stage_state;
  logic [2:0] bank_we;
  logic [1:0] wr_slot;
  logic [1:0] main_sel;
  logic [1:0] nbr_sel;
  logic       main_valid;
  logic       nbr_valid;
  logic       stall;
  logic [1:0] rd_bank;
  logic [1:0] rd_slot;
  logic       rd_ok;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  frame_bank_ctrl i_frame_bank_ctrl (
    .clk(clk), .rst(rst), .stage_done(stage_done), .frame_wr_done(frame_wr_done),
    .rd_idx(rd_idx), .stage_state(stage_state), .bank_we(bank_we), .wr_slot(wr_slot),
    .main_sel(main_sel), .nbr_sel(nbr_sel), .main_valid(main_valid),
    .nbr_valid(nbr_valid), .stall(stall), .rd_bank(rd_bank), .rd_slot(rd_slot),
    .rd_ok(rd_ok)
  );

  // [9] stage_done [8] frame_wr_done [7:6] state [5:3] bank_we [2:1] wr_slot [0] stall
  localparam logic [9:0] VEC [0:17] = '{
    10'b01_00_001_01_0,
    10'b01_00_001_10_0,
    10'b01_00_001_11_0,
    10'b10_00_001_11_1,
    10'b10_00_001_11_1,
    10'b01_00_000_11_1,
    10'b00_10_010_00_0,
    10'b01_10_010_01_0,
    10'b01_10_010_10_0,
    10'b01_10_010_11_0,
    10'b01_10_000_11_0,
    10'b01_10_000_11_0,
    10'b10_01_100_00_0,
    10'b11_01_100_01_1,
    10'b01_01_100_10_1,
    10'b01_01_100_11_1,
    10'b01_01_000_11_1,
    10'b00_00_001_00_0
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(logic sd, logic wr);
    @(negedge clk);
    stage_done    = sd;
    frame_wr_done = wr;
    @(negedge clk);
    stage_done    = 1'b0;
    frame_wr_done = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_reset(string tag);
    chk({tag, " state"}, 32'(stage_state), 32'h0);
    chk({tag, " bank_we"}, 32'(bank_we), 32'h1);
    chk({tag, " wr_slot"}, 32'(wr_slot), 32'h0);
    chk({tag, " main_sel"}, 32'(main_sel), 32'h2);
    chk({tag, " nbr_sel"}, 32'(nbr_sel), 32'h1);
    chk({tag, " stall"}, 32'(stall), 32'h0);
    chk({tag, " valids"}, {30'd0, main_valid, nbr_valid}, 32'h0);
    chk({tag, " rd_ok"}, 32'(rd_ok), 32'h0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        checks++;
        errors++;
        $display("FAIL watchdog: got %0d cycles expected under 20000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    rst = 1'b1;
    stage_done = 1'b0;
    frame_wr_done = 1'b0;
    rd_idx = 3'd0;
    repeat (3) @(negedge clk);
    check_reset("R1 during reset");
    rst = 1'b0;
    @(negedge clk);
    check_reset("R1 after release");

    // Table walk: writes, stall, ignored pulses, rotation through all states
    for (int i = 0; i < 18; i++) begin
      step(VEC[i][9], VEC[i][8]);
      chk($sformatf("R2/R4/R5 state vec%0d", i), 32'(stage_state), 32'(VEC[i][7:6]));
      chk($sformatf("R3 bank_we vec%0d", i), 32'(bank_we), 32'(VEC[i][5:3]));
      chk($sformatf("R3 wr_slot vec%0d", i), 32'(wr_slot), 32'(VEC[i][2:1]));
      chk($sformatf("R5/R9 stall vec%0d", i), 32'(stall), 32'(VEC[i][0]));
    end
    // three advances happened: both valid
    chk("R6 main_valid after 3 advances", 32'(main_valid), 32'h1);
    chk("R6 nbr_valid after 3 advances", 32'(nbr_valid), 32'h1);

    // Directed: reset again, registered selects, validity and read map
    do_reset();
    check_reset("R1 second reset");
    for (int k = 0; k < 4; k++) step(1'b0, 1'b1);
    step(1'b1, 1'b0);
    chk("R4 immediate advance state", 32'(stage_state), 32'h2);
    chk("R4 new write bank", 32'(bank_we), 32'h2);
    chk("R7 main_sel lags", 32'(main_sel), 32'h2);
    chk("R7 nbr_sel lags", 32'(nbr_sel), 32'h1);
    chk("R6 main_valid first advance", 32'(main_valid), 32'h1);
    chk("R6 nbr_valid first advance", 32'(nbr_valid), 32'h0);
    rd_idx = 3'd1;
    @(negedge clk);
    chk("R7 main_sel updated", 32'(main_sel), 32'h0);
    chk("R7 nbr_sel updated", 32'(nbr_sel), 32'h2);
    chk("R8 idx1 bank", 32'(rd_bank), 32'h2);
    chk("R8 idx1 slot", 32'(rd_slot), 32'h1);
    chk("R8 idx1 ok", 32'(rd_ok), 32'h0);
    rd_idx = 3'd6;
    @(negedge clk);
    chk("R8 idx6 bank", 32'(rd_bank), 32'h0);
    chk("R8 idx6 slot", 32'(rd_slot), 32'h2);
    chk("R8 idx6 ok", 32'(rd_ok), 32'h1);

    for (int k = 0; k < 4; k++) step(1'b0, 1'b1);
    step(1'b1, 1'b0);
    chk("R2 second advance state", 32'(stage_state), 32'h1);
    chk("R6 nbr_valid second advance", 32'(nbr_valid), 32'h1);
    rd_idx = 3'd2;
    @(negedge clk);
    chk("R7 main_sel state01", 32'(main_sel), 32'h1);
    chk("R7 nbr_sel state01", 32'(nbr_sel), 32'h0);
    chk("R8 idx2 bank", 32'(rd_bank), 32'h0);
    chk("R8 idx2 slot", 32'(rd_slot), 32'h2);
    chk("R8 idx2 ok", 32'(rd_ok), 32'h1);
    rd_idx = 3'd7;
    @(negedge clk);
    chk("R8 idx7 bank", 32'(rd_bank), 32'h1);
    chk("R8 idx7 slot", 32'(rd_slot), 32'h3);

    finish_run();
  end

endmodule